// File: doc/BRIEF.md
# Weighted Thread Issue Scheduler

This block decides, in every cycle, which one of up to nine hardware thread contexts may send an instruction into a shared execution pipeline. Each context raises a ready bit when it has work. Two policies act together. A per-thread priority lets urgent threads win over others. A per-thread share sets how many cycles that thread is owed within each fixed 64-cycle window. Threads that still have share credit left are served first, and the highest priority among them wins. Once every ready thread has spent its credit, the choice falls back to priority alone, so the pipeline never sits idle while any thread is ready.

The contexts are split into two virtual processing elements: the lower-numbered group and the upper group. The scheduler reports which of the two groups owns the issuing thread. The grant decision is combinational from the ready bits and the stored credit and rotation state. The grant therefore belongs to the same cycle as the ready bits that produced it. Credits, the window counter and the rotation pointer advance on the clock edge that closes that cycle.

Top module: `weighted_issue_sched`

## Requirements
- R1: `grant_o` has at most one bit set, and it is all zero exactly when `ready_i` is all zero.
- R2: A grant bit is set only for a thread whose ready bit is set in the same cycle.
- R3: Among the ready threads that still hold credit, the thread with the numerically largest priority wins. Thread i's priority is `prio_i[i*PRIO_W +: PRIO_W]`.
- R4: When several candidates share the top priority, the winner is the first of them found by scanning upward from the index after the most recently granted thread, wrapping from the last thread to thread 0. The scan start moves only in cycles that have a grant.
- R5: Every grant to a thread with nonzero credit spends one unit of that credit. A ready thread with zero credit loses to any ready thread that still has credit, whatever their priorities.
- R6: When no ready thread has credit, the grant goes to the ready thread with the largest priority, with ties broken as in R4.
- R7: Cycles are counted from reset in windows of WINDOW (64) cycles. At the clock edge that ends the last cycle of each window, every thread's credit is reloaded from `share_i[i*SHARE_W +: SHARE_W]` and any unspent credit is dropped.
- R8: Synchronous active-low reset loads every credit from `share_i`, clears the window count and sets the scan start to thread 0.
- R9: `issue_vpe_o` is 0 when the granted thread index is below VPE0_THREADS (default 5: threads 0 to 4). It is 1 for threads 5 and up. It is 0 when nothing is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ready_i | input | NUM_THREADS | One ready bit per thread context |
| prio_i | input | NUM_THREADS*PRIO_W | Packed per-thread priority, larger is more urgent |
| share_i | input | NUM_THREADS*SHARE_W | Packed per-thread cycle share per window |
| grant_o | output | NUM_THREADS | One-hot issue grant, zero when no thread is ready |
| issue_vpe_o | output | 1 | Processing element group owning the granted thread |

## Verification
The grant and the group output are due in the same cycle as the ready bits, so the bench drives inputs just after a falling edge and samples one time unit later, before the next rising edge. A spent credit or an advanced scan start shows up one cycle after the grant that caused it. The bench therefore counts cycles from reset release and compares each cycle's grant with a sequence worked out by hand from the rules. The window reload is checked at cycle 64 after reset, the first cycle of the second window, where the credit restored at the end of cycle 63 must again favour the high-priority thread.

// File: rtl/wts_pkg.sv
// Shared definitions for the weighted thread issue scheduler.
// Assumes thread indices fit in an int.
package wts_pkg;

    // Processing element group owning a thread context
    typedef enum logic {
        GRP_LOW  = 1'b0,
        GRP_HIGH = 1'b1
    } grp_sel_e;

    // Next index in a cyclic order of n entries
    function automatic int wrap_next(input int idx, input int n);
        return (idx >= n - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/wts_window_timer.sv
// Free-running cycle counter that marks the final cycle of each
// fixed-length window. Assumes WINDOW >= 2.
module wts_window_timer #(
    parameter int WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic window_end_o
);
    localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles since reset, wrapping at the window length
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Flag the last cycle of the current window
    always_comb window_end_o = (cnt_q == LAST);

endmodule

// File: rtl/wts_credit_bank.sv
// One credit counter per thread. A counter reloads from the
// programmed share at reset and at each window end, otherwise
// it drops by one for each grant it receives while nonzero.
// Assumes grant_i carries at most one set bit.
module wts_credit_bank #(
    parameter int NUM_THREADS = 9,
    parameter int SHARE_W     = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reload_i,
    input  logic [NUM_THREADS-1:0] grant_i,
    input  logic [SHARE_W-1:0]     share_i [NUM_THREADS],
    output logic [NUM_THREADS-1:0] has_credit_o
);
    genvar t;
    generate
        for (t = 0; t < NUM_THREADS; t++) begin : g_thr
            logic [SHARE_W-1:0] credit_q;

            // Reload on reset or window end, else spend on grant
            always_ff @(posedge clk) begin
                if (!rst_n || reload_i)
                    credit_q <= share_i[t];
                else if (grant_i[t] && credit_q != '0)
                    credit_q <= credit_q - 1'b1;
            end

            // Report whether any credit remains for this thread
            always_comb has_credit_o[t] = (credit_q != '0);
        end
    endgenerate

endmodule

// File: rtl/wts_pick.sv
// Combinational selector: finds the largest priority in the
// candidate pool, then picks the first tied candidate at or
// after the rotation start, wrapping around.
// Assumes start_i < NUM_THREADS.
module wts_pick #(
    parameter int NUM_THREADS = 9,
    parameter int PRIO_W      = 3,
    parameter int IDX_W       = 4
) (
    input  logic [NUM_THREADS-1:0] pool_i,
    input  logic [PRIO_W-1:0]      prio_i [NUM_THREADS],
    input  logic [IDX_W-1:0]       start_i,
    output logic [NUM_THREADS-1:0] grant_o,
    output logic [IDX_W-1:0]       idx_o,
    output logic                   valid_o
);
    logic [PRIO_W-1:0]      top_prio;
    logic [NUM_THREADS-1:0] tied;

    // Find the largest priority among pool members
    always_comb begin
        top_prio = '0;
        for (int i = 0; i < NUM_THREADS; i++)
            if (pool_i[i] && prio_i[i] > top_prio)
                top_prio = prio_i[i];
    end

    // Mark pool members that hold the largest priority
    always_comb begin
        for (int i = 0; i < NUM_THREADS; i++)
            tied[i] = pool_i[i] && (prio_i[i] == top_prio);
    end

    // Rotating scan: first tied member from the start index
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        valid_o = 1'b0;
        for (int k = 0; k < NUM_THREADS; k++) begin
            int j;
            j = int'(start_i) + k;
            if (j >= NUM_THREADS)
                j = j - NUM_THREADS;
            if (!valid_o && tied[j]) begin
                valid_o    = 1'b1;
                grant_o[j] = 1'b1;
                idx_o      = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/weighted_issue_sched.sv
// Top of the weighted thread issue scheduler. Threads with credit
// left in the current window are served first by priority; if
// none of the ready threads has credit, all ready threads compete
// by priority. Ties rotate. Grant is combinational from ready_i.
// Assumes prio_i and share_i are held stable while in use.
module weighted_issue_sched #(
    parameter int NUM_THREADS  = 9,
    parameter int PRIO_W       = 3,
    parameter int WINDOW       = 64,
    parameter int SHARE_W      = 7,
    parameter int VPE0_THREADS = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_THREADS-1:0]         ready_i,
    input  logic [NUM_THREADS*PRIO_W-1:0]  prio_i,
    input  logic [NUM_THREADS*SHARE_W-1:0] share_i,
    output logic [NUM_THREADS-1:0]         grant_o,
    output logic                           issue_vpe_o
);
    import wts_pkg::*;

    localparam int IDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;

    logic [PRIO_W-1:0]      prio_arr  [NUM_THREADS];
    logic [SHARE_W-1:0]     share_arr [NUM_THREADS];
    logic [NUM_THREADS-1:0] has_credit;
    logic [NUM_THREADS-1:0] eligible;
    logic [NUM_THREADS-1:0] pool;
    logic [NUM_THREADS-1:0] grant;
    logic [IDX_W-1:0]       grant_idx;
    logic                   grant_valid;
    logic [IDX_W-1:0]       start_q;
    logic                   window_end;
    grp_sel_e               grp;

    // Unpack the per-thread configuration fields
    genvar t;
    generate
        for (t = 0; t < NUM_THREADS; t++) begin : g_unpack
            assign prio_arr[t]  = prio_i[t*PRIO_W +: PRIO_W];
            assign share_arr[t] = share_i[t*SHARE_W +: SHARE_W];
        end
    endgenerate

    wts_window_timer #(
        .WINDOW (WINDOW)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .window_end_o (window_end)
    );

    wts_credit_bank #(
        .NUM_THREADS (NUM_THREADS),
        .SHARE_W     (SHARE_W)
    ) u_credit (
        .clk          (clk),
        .rst_n        (rst_n),
        .reload_i     (window_end),
        .grant_i      (grant),
        .share_i      (share_arr),
        .has_credit_o (has_credit)
    );

    // Credited threads go first; with none, every ready thread competes
    always_comb begin
        eligible = ready_i & has_credit;
        pool     = (eligible != '0) ? eligible : ready_i;
    end

    wts_pick #(
        .NUM_THREADS (NUM_THREADS),
        .PRIO_W      (PRIO_W),
        .IDX_W       (IDX_W)
    ) u_pick (
        .pool_i  (pool),
        .prio_i  (prio_arr),
        .start_i (start_q),
        .grant_o (grant),
        .idx_o   (grant_idx),
        .valid_o (grant_valid)
    );

    // Move the rotation start past the thread just granted
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= '0;
        else if (grant_valid)
            start_q <= IDX_W'(wrap_next(int'(grant_idx), NUM_THREADS));
    end

    // Map the granted index to its processing element group
    always_comb begin
        if (grant_valid && int'(grant_idx) >= VPE0_THREADS)
            grp = GRP_HIGH;
        else
            grp = GRP_LOW;
    end

    assign grant_o     = grant;
    assign issue_vpe_o = grp;

endmodule

// File: rtl/wts_checker.sv
// Property checker for the weighted thread issue scheduler,
// attached to every instance of the top through bind.
module wts_checker #(
    parameter int NUM_THREADS  = 9,
    parameter int PRIO_W       = 3,
    parameter int VPE0_THREADS = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_THREADS-1:0]        ready_i,
    input logic [NUM_THREADS*PRIO_W-1:0] prio_i,
    input logic [NUM_THREADS-1:0]        grant_o,
    input logic                          issue_vpe_o,
    input logic [NUM_THREADS-1:0]        has_credit
);
    logic [NUM_THREADS-1:0] cand;
    logic [PRIO_W-1:0]      best;
    logic [PRIO_W-1:0]      won;
    logic                   upper;

    // Reference best priority and the granted thread's priority
    always_comb begin
        cand  = ((ready_i & has_credit) != '0) ? (ready_i & has_credit) : ready_i;
        best  = '0;
        won   = '0;
        upper = 1'b0;
        for (int i = 0; i < NUM_THREADS; i++) begin
            if (cand[i] && prio_i[i*PRIO_W +: PRIO_W] > best)
                best = prio_i[i*PRIO_W +: PRIO_W];
            if (grant_o[i]) begin
                won   = prio_i[i*PRIO_W +: PRIO_W];
                upper = (i >= VPE0_THREADS);
            end
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R1
    AST_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i != '0) |-> (grant_o != '0)); // R1
    AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~ready_i) == '0); // R2
    AST_CREDIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((ready_i & has_credit) != '0) |-> ((grant_o & has_credit) != '0)); // R5
    AST_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i != '0) |-> (won == best)); // R3
    AST_GROUP_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vpe_o == upper); // R9

endmodule

bind weighted_issue_sched wts_checker #(
    .NUM_THREADS  (NUM_THREADS),
    .PRIO_W       (PRIO_W),
    .VPE0_THREADS (VPE0_THREADS)
) u_wts_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_i     (ready_i),
    .prio_i      (prio_i),
    .grant_o     (grant_o),
    .issue_vpe_o (issue_vpe_o),
    .has_credit  (has_credit)
);

// File: tb/weighted_issue_sched_test.sv
module weighted_issue_sched_test;
    localparam int PERIOD = 10;
    localparam int N  = 9;
    localparam int PW = 3;
    localparam int SW = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    ready = '0;
    logic [N*PW-1:0] prio = '0;
    logic [N*SW-1:0] share = '0;
    logic [N-1:0]    grant;
    logic            vpe;
    int n_checks = 0;
    int n_fail   = 0;

    // Fields: ready, high-priority mask, zero-share mask, expected grant, expected group
    localparam logic [36:0] VEC [0:7] = '{
        {9'h000, 9'h000, 9'h000, 9'h000, 1'b0},   // R1 nothing ready
        {9'h010, 9'h000, 9'h000, 9'h010, 1'b0},   // R2 single ready
        {9'h1FF, 9'h000, 9'h000, 9'h001, 1'b0},   // R4 tie from start 0
        {9'h0A4, 9'h080, 9'h000, 9'h080, 1'b1},   // R3 highest priority
        {9'h0A4, 9'h080, 9'h080, 9'h004, 1'b0},   // R5 no credit loses
        {9'h0A4, 9'h080, 9'h0A4, 9'h080, 1'b1},   // R6 fallback to priority
        {9'h100, 9'h000, 9'h000, 9'h100, 1'b1},   // R9 last thread upper group
        {9'h030, 9'h030, 9'h000, 9'h010, 1'b0}    // R9 thread 4 lower group
    };

    weighted_issue_sched uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_i     (ready),
        .prio_i      (prio),
        .share_i     (share),
        .grant_o     (grant),
        .issue_vpe_o (vpe)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reset with configuration applied; returns in cycle 0 after release
    task automatic do_reset(input logic [N*PW-1:0] p, input logic [N*SW-1:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        ready = '0;
        prio  = p;
        share = s;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [N*PW-1:0] mk_prio(input logic [N-1:0] hi, input int hv, input int lv);
        logic [N*PW-1:0] r;
        for (int i = 0; i < N; i++) r[i*PW +: PW] = hi[i] ? PW'(hv) : PW'(lv);
        return r;
    endfunction

    function automatic logic [N*SW-1:0] mk_share(input logic [N-1:0] zs, input int v);
        logic [N*SW-1:0] r;
        for (int i = 0; i < N; i++) r[i*SW +: SW] = zs[i] ? '0 : SW'(v);
        return r;
    endfunction

    // Watchdog: a hung run counts as a failure
    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] rr_exp [0:13];
        // Reset state: nothing granted, group low (R8, R1)
        do_reset(mk_prio('0, 1, 1), mk_share('0, 10));
        #1;
        check("R8 reset grant", grant, '0);
        check("R8 reset group", {8'b0, vpe}, '0);

        // Vector table, each entry in cycle 0 after reset
        for (int v = 0; v < 8; v++) begin
            do_reset(mk_prio(VEC[v][27:19], 5, 1), mk_share(VEC[v][18:10], 10));
            ready = VEC[v][36:28];
            #1;
            check($sformatf("R1-table %0d grant", v), grant, VEC[v][9:1]);
            check($sformatf("R9 table %0d group", v), {8'b0, vpe}, {8'b0, VEC[v][0]});
        end

        // R4 rotation over all threads, then a sparse set (1,5,8)
        rr_exp = '{9'h001, 9'h002, 9'h004, 9'h008, 9'h010, 9'h020, 9'h040,
                   9'h080, 9'h100, 9'h001, 9'h002, 9'h020, 9'h100, 9'h002};
        do_reset(mk_prio('0, 1, 1), mk_share('0, 10));
        for (int c = 0; c < 14; c++) begin
            if (c > 0) @(negedge clk);
            ready = (c < 10) ? 9'h1FF : 9'h122;
            #1;
            check($sformatf("R4 rotation cycle %0d", c), grant, rr_exp[c]);
        end

        // R5/R6/R7: thread0 prio 7 share 3, thread1 prio 1 share 10
        do_reset(mk_prio(9'h001, 7, 1), mk_share(9'h1FC, 0) | {{(N-2)*SW{1'b0}}, 7'd10, 7'd3});
        for (int c = 0; c < 68; c++) begin
            logic [N-1:0] e;
            if (c > 0) @(negedge clk);
            ready = 9'h003;
            #1;
            if (c < 3 || (c >= 13 && c < 67)) e = 9'h001; else e = 9'h002;
            if (c == 2 || c == 3 || c == 12)
                check($sformatf("R5 credit cycle %0d", c), grant, e);
            if (c == 13 || c == 63)
                check($sformatf("R6 fallback cycle %0d", c), grant, e);
            if (c == 64 || c == 66 || c == 67)
                check($sformatf("R7 reload cycle %0d", c), grant, e);
        end

        // R2: dropping ready removes the grant in the same cycle
        @(negedge clk);
        ready = '0;
        #1;
        check("R2 no ready no grant", grant, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule